// File: doc/BRIEF.md
# Serial channel interrupt register unit

This block holds the interrupt control state of a serial channel. Thirteen event sources feed it. Each source arrives as a one-cycle pulse on one bit of an event vector. The sources are the receive and transmit FIFO levels (trigger, empty, full, near-full, overflow), the receive errors (overrun, framing, parity), the receive timeout and a modem-line change. Every pulse is caught in a sticky status bit. Software clears a status bit by writing a one to it.

Software turns sources on and off through two write-only ports. One sets enable bits and the other clears them; in both, a zero bit leaves the enable unchanged. The current enable set can be read back as a mask. A single interrupt line is raised while any caught event is also enabled. That line comes from a flop, so it cannot glitch.

Top module: `irq_reg_unit`

## Requirements
- R1: Bit positions on the event, write-data, mask and status vectors are: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overrun, 6 receive framing, 7 receive parity, 8 receive timeout, 9 modem change, 10 transmit trigger, 11 transmit near-full, 12 transmit overflow. A pulse on event bit i sets status bit i only.
- R2: A write to the enable-set port makes the mask bit a one wherever the data bit is one. Mask bits under zero data bits keep their value.
- R3: A write to the enable-clear port makes the mask bit a zero wherever the data bit is one. Mask bits under zero data bits keep their value.
- R4: If both enable ports are written in the same cycle, the clear wins on any bit that both select.
- R5: An event pulse sets its status bit on the next clock edge, whether or not its source is enabled.
- R6: A status bit stays set until software clears it with a write, even after its event pulse has ended.
- R7: A status write clears every status bit whose data bit is one and leaves the others alone. One write can clear the overrun, framing and parity bits (mask 0x0E0) together.
- R8: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: After reset, the mask, the status and the interrupt output are all zero.
- R10: The interrupt output equals the OR over all bits of (status AND mask), taken one clock later than the register values it is computed from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 13 | One-cycle event pulses, one bit per source |
| en_set_we | input | 1 | Write strobe for the enable-set port |
| en_set_data | input | 13 | Ones select the sources to enable |
| en_clr_we | input | 1 | Write strobe for the enable-clear port |
| en_clr_data | input | 13 | Ones select the sources to disable |
| sts_clr_we | input | 1 | Write strobe for the status clear |
| sts_clr_data | input | 13 | Ones select the status bits to clear |
| mask_rd | output | 13 | Currently enabled sources |
| status_rd | output | 13 | Sticky event status |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check the following on every cycle:
- the set and clear effect of the enable ports, with the clear winning on overlap;
- the capture of every event pulse regardless of its enable, with the event winning over a same-cycle clear;
- that the mask holds its value when neither enable port is written;
- the one-cycle relation between the interrupt output and the enabled status.

Some behaviours show only in the bench's scenarios, which run against a behavioural model compared every clock:
- that zero data bits leave other bits untouched across a sequence of writes;
- that the three receive error bits clear together in one write;
- that each event lands in its documented bit position;
- the reset state;
- the interrupt rising and falling as the enables and the status change.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  localparam int unsigned IRQ_SRC_COUNT = 13;

  // Source bit positions; software decodes these.
  localparam int unsigned SRC_RX_TRIG     = 0;
  localparam int unsigned SRC_RX_EMPTY    = 1;
  localparam int unsigned SRC_RX_FULL     = 2;
  localparam int unsigned SRC_TX_EMPTY    = 3;
  localparam int unsigned SRC_TX_FULL     = 4;
  localparam int unsigned SRC_RX_OVERRUN  = 5;
  localparam int unsigned SRC_RX_FRAMING  = 6;
  localparam int unsigned SRC_RX_PARITY   = 7;
  localparam int unsigned SRC_RX_TIMEOUT  = 8;
  localparam int unsigned SRC_MODEM_CHG   = 9;
  localparam int unsigned SRC_TX_TRIG     = 10;
  localparam int unsigned SRC_TX_NEARFULL = 11;
  localparam int unsigned SRC_TX_OVERFLOW = 12;

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic [N-1:0] set_data,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] mask_q
);

  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    set_vec = set_we ? set_data : '0;
    clr_vec = clr_we ? clr_data : '0;
    mask_en = set_we | clr_we;
    // clear is applied last so it wins on overlapping bits
    mask_d  = (mask_q | set_vec) & ~clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] sts_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_clr;
    logic bit_en;
    logic bit_d;

    always_comb begin
      bit_clr = clr_we & clr_data[i];
      bit_en  = evt[i] | bit_clr;
      // a same-cycle event overrides the clear
      bit_d   = evt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q[i] <= 1'b0;
      end else if (bit_en) begin
        sts_q[i] <= bit_d;
      end
    end
  end

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sts,
  input  logic [N-1:0] mask,
  output logic         irq_q
);

  logic irq_d;

  always_comb begin
    irq_d = |(sts & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/irq_reg_unit.sv
module irq_reg_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned N_SRC = IRQ_SRC_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_pulse,
  input  logic             en_set_we,
  input  logic [N_SRC-1:0] en_set_data,
  input  logic             en_clr_we,
  input  logic [N_SRC-1:0] en_clr_data,
  input  logic             sts_clr_we,
  input  logic [N_SRC-1:0] sts_clr_data,
  output logic [N_SRC-1:0] mask_rd,
  output logic [N_SRC-1:0] status_rd,
  output logic             irq
);

  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] sts_q;

  irq_mask_reg #(.N(N_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (en_set_we),
    .set_data (en_set_data),
    .clr_we   (en_clr_we),
    .clr_data (en_clr_data),
    .mask_q   (mask_q)
  );

  irq_status_bank #(.N(N_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .clr_we   (sts_clr_we),
    .clr_data (sts_clr_data),
    .sts_q    (sts_q)
  );

  irq_out_reg #(.N(N_SRC)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .sts   (sts_q),
    .mask  (mask_q),
    .irq_q (irq)
  );

  assign mask_rd   = mask_q;
  assign status_rd = sts_q;

endmodule

// File: rtl/irq_reg_unit_chk.sv
module irq_reg_unit_chk #(
  parameter int unsigned N = 13
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt_pulse,
  input logic         en_set_we,
  input logic [N-1:0] en_set_data,
  input logic         en_clr_we,
  input logic [N-1:0] en_clr_data,
  input logic         sts_clr_we,
  input logic [N-1:0] sts_clr_data,
  input logic [N-1:0] mask_rd,
  input logic [N-1:0] status_rd,
  input logic         irq
);

  logic [N-1:0] clr_sel;
  assign clr_sel = en_clr_we ? en_clr_data : '0;

  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we |=> ((mask_rd & $past(en_set_data & ~clr_sel)) == $past(en_set_data & ~clr_sel)));

  // R4: the clear side wins, so every selected bit ends up zero
  assert_enable_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> ((mask_rd & $past(en_clr_data)) == '0));

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_set_we && !en_clr_we) |=> $stable(mask_rd));

  // R8: holds even when a clearing write hits the same bit
  assert_event_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((status_rd & $past(evt_pulse)) == $past(evt_pulse)));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_clr_we) |=> ((status_rd & $past(status_rd)) == $past(status_rd)));

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status_rd & mask_rd))));

endmodule

bind irq_reg_unit irq_reg_unit_chk #(.N(N_SRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_pulse    (evt_pulse),
  .en_set_we    (en_set_we),
  .en_set_data  (en_set_data),
  .en_clr_we    (en_clr_we),
  .en_clr_data  (en_clr_data),
  .sts_clr_we   (sts_clr_we),
  .sts_clr_data (sts_clr_data),
  .mask_rd      (mask_rd),
  .status_rd    (status_rd),
  .irq          (irq)
);

// File: tb/tb_irq_reg_unit.sv
`timescale 1ns/1ps
module tb_irq_reg_unit;

  localparam int N = 13;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] evt_pulse;
  logic         en_set_we;
  logic [N-1:0] en_set_data;
  logic         en_clr_we;
  logic [N-1:0] en_clr_data;
  logic         sts_clr_we;
  logic [N-1:0] sts_clr_data;
  logic [N-1:0] mask_rd;
  logic [N-1:0] status_rd;
  logic         irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  logic [N-1:0] m_mask;
  logic [N-1:0] m_sts;
  logic         m_irq;

  irq_reg_unit dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .en_set_we(en_set_we), .en_set_data(en_set_data),
    .en_clr_we(en_clr_we), .en_clr_data(en_clr_data),
    .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
    .mask_rd(mask_rd), .status_rd(status_rd), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= '0;
      m_sts  <= '0;
      m_irq  <= 1'b0;
    end else begin
      logic [N-1:0] nm;
      logic [N-1:0] ns;
      nm = m_mask;
      ns = m_sts;
      for (int i = 0; i < N; i++) begin
        if (en_set_we && en_set_data[i]) nm[i] = 1'b1;
        if (en_clr_we && en_clr_data[i]) nm[i] = 1'b0;
        if (sts_clr_we && sts_clr_data[i]) ns[i] = 1'b0;
        if (evt_pulse[i]) ns[i] = 1'b1;
      end
      m_irq  <= ((m_sts & m_mask) != 0);
      m_mask <= nm;
      m_sts  <= ns;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // compare against the model every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 R3 R4 mask vs model", int'(mask_rd), int'(m_mask));
      check("R5 R6 R7 R8 status vs model", int'(status_rd), int'(m_sts));
      check("R10 irq vs model", int'(irq), int'(m_irq));
    end
  end

  task automatic finish_up();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<5000", cycles);
      finish_up();
    end
  end

  // drive one cycle of stimulus; returns at the following negedge
  task automatic step(input logic sw, input logic [N-1:0] sd,
                      input logic cw, input logic [N-1:0] cd,
                      input logic aw, input logic [N-1:0] ad,
                      input logic [N-1:0] ev);
    en_set_we = sw; en_set_data = sd;
    en_clr_we = cw; en_clr_data = cd;
    sts_clr_we = aw; sts_clr_data = ad;
    evt_pulse = ev;
    @(negedge clk);
    en_set_we = 0; en_set_data = '0;
    en_clr_we = 0; en_clr_data = '0;
    sts_clr_we = 0; sts_clr_data = '0;
    evt_pulse = '0;
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, '0, '0);
  endtask

  initial begin
    rst_n = 0;
    evt_pulse = '0;
    en_set_we = 0; en_set_data = '0;
    en_clr_we = 0; en_clr_data = '0;
    sts_clr_we = 0; sts_clr_data = '0;
    repeat (3) @(negedge clk);
    check("R9 reset mask", int'(mask_rd), 0);
    check("R9 reset status", int'(status_rd), 0);
    check("R9 reset irq", int'(irq), 0);
    rst_n = 1;
    @(negedge clk);

    step(1, 13'h0005, 0, '0, 0, '0, '0);
    check("R2 set first", int'(mask_rd), 'h0005);
    step(1, 13'h0100, 0, '0, 0, '0, '0);
    check("R2 zeros keep bits", int'(mask_rd), 'h0105);
    step(0, '0, 1, 13'h0001, 0, '0, '0);
    check("R3 clear one bit", int'(mask_rd), 'h0104);
    step(1, 13'h0030, 1, 13'h0010, 0, '0, '0);
    check("R4 clear wins", int'(mask_rd), 'h0124);

    step(0, '0, 0, '0, 0, '0, 13'h0008);
    check("R5 disabled source captured", int'(status_rd), 'h0008);
    idle();
    check("R5 no irq when disabled", int'(irq), 0);
    repeat (3) idle();
    check("R6 status sticky", int'(status_rd), 'h0008);

    step(0, '0, 0, '0, 0, '0, 13'h00E0);
    check("R7 errors captured", int'(status_rd), 'h00E8);
    step(0, '0, 0, '0, 1, 13'h00E0, '0);
    check("R7 error trio cleared", int'(status_rd), 'h0008);

    step(0, '0, 0, '0, 1, 13'h0100, 13'h0100);
    check("R8 event beats clear", int'(status_rd), 'h0108);
    check("R10 irq not yet", int'(irq), 0);
    idle();
    check("R10 irq raised", int'(irq), 1);
    step(0, '0, 1, 13'h0100, 0, '0, '0);
    check("R10 irq one cycle late", int'(irq), 1);
    idle();
    check("R10 irq dropped", int'(irq), 0);

    step(0, '0, 0, '0, 1, 13'h1FFF, '0);
    check("R7 clear all", int'(status_rd), 0);
    for (int i = 0; i < N; i++) begin
      step(0, '0, 0, '0, 0, '0, 13'(1) << i);
      check($sformatf("R1 event position %0d", i), int'(status_rd), 1 << i);
      step(0, '0, 0, '0, 1, 13'h1FFF, '0);
    end
    check("R1 parity at bit 7", int'(status_rd), 0);
    step(0, '0, 0, '0, 0, '0, 13'(1) << 7);
    check("R1 parity bit", int'(status_rd[7]), 1);

    repeat (2) idle();
    finish_up();
  end

endmodule